// File: doc/BRIEF.md
# Rotating Layer Fetch Address Generator

This block produces the byte addresses a display layer uses to read its pixels from a framebuffer in memory. A frame-start pulse captures a source rectangle, a rotation code, the number of colour planes and, for each plane, a line pitch, a bytes-per-pixel count and a buffer base. The block then walks the rectangle in output order and hands out one address per pixel on a valid/ready handshake. Plane 0 is walked first, then plane 1, then plane 2.

Rotation costs no buffering. For each plane the block derives a start offset, a signed step applied between pixels of an output line and a signed step applied at each line end. It adds these to a running pointer, so a quarter or half turn is only a different walk through memory. Chroma planes take horizontal and vertical subsampling factors. Each factor is a power of two, given as a shift count, and it scales the rectangle coordinates for those planes.

Top module: `rot_fetch_agen`

## Requirements
- R1: While reset is low and after it is released, `out_valid` and `out_last` are 0 until a frame start.
- R2: The cycle after `sof` is sampled high, `out_valid` is 0. The first address of the frame is valid in the following cycle. Configuration inputs are captured only when `sof` is high, and changes at any other time have no effect on the frame.
- R3: Rotation code 0 (no turn): line l, pixel k reads source row y0+l and column x0+k. There are cols pixels per line and rows lines. Here x0=x>>s, x1=(x+w-1)>>s, cols=((w-1)>>s)+1, and the same holds vertically.
- R4: Rotation code 2 (half turn): line l, pixel k reads row y1-l and column x1-k. There are cols pixels per line and rows lines.
- R5: Rotation code 1 (quarter turn): line l, pixel k reads row y0+k and column x1-l. Width and height swap, giving rows pixels per line and cols lines.
- R6: Rotation code 3 (three-quarter turn): line l, pixel k reads row y1-k and column x0+l. There are rows pixels per line and cols lines.
- R7: Plane 0 uses shift 0. Planes 1 and 2 use `cfg_hsub` horizontally and `cfg_vsub` vertically. Planes are walked in increasing index, and `out_plane` gives the index. Rectangles are aligned so that x and w are multiples of 2^hsub, and y and h are multiples of 2^vsub.
- R8: Every address equals the plane's base + row*pitch + column*bpp, computed modulo 2^32.
- R9: `out_valid` is 0 for exactly one cycle between planes. After the final address is accepted, it stays 0 until the next `sof`.
- R10: `out_last` is 1 only with the final address of the final plane.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_addr`, `out_plane` and `out_last` hold.
- R12: A `sof` during a frame abandons that frame and starts the new configuration with R2 timing. No transfer happens in a cycle with `sof` high.
- R13: `cfg_planes_m1` holds the plane count minus one. The value 3 is treated as 2, so three planes are walked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Frame start: captures configuration, restarts the walk |
| cfg_rot | input | 2 | Rotation code: 0, 1=quarter, 2=half, 3=three-quarter turn |
| cfg_planes_m1 | input | 2 | Plane count minus one |
| cfg_x | input | CW | Rectangle left column |
| cfg_y | input | CW | Rectangle top row |
| cfg_w | input | CW | Rectangle width in pixels (at least 1) |
| cfg_h | input | CW | Rectangle height in lines (at least 1) |
| cfg_hsub | input | 2 | Horizontal subsampling shift for planes 1 and 2 |
| cfg_vsub | input | 2 | Vertical subsampling shift for planes 1 and 2 |
| cfg_pitch | input | NPL*AW | Line pitch in bytes per plane, plane 0 in the low slice |
| cfg_bpp | input | NPL*BW | Bytes per pixel per plane |
| cfg_base | input | NPL*AW | Buffer base address per plane |
| out_valid | output | 1 | Address available |
| out_ready | input | 1 | Consumer takes the address |
| out_addr | output | AW | Byte address of the pixel |
| out_plane | output | 2 | Plane index of the address |
| out_last | output | 1 | Final address of the frame |

## Verification
The address register is loaded on the second edge after `sof` is sampled. The bench therefore expects `out_valid` low on the first falling edge after the pulse and the first address on the second. Each accepted address moves the pointer on the following edge, so the bench checks an address at the falling edge where it raises `out_ready`, and then steps its model. A plane change inserts exactly one load cycle, which is checked at the falling edge right after the last address of the plane. All values are compared at falling edges against a row/column model of every rotation, which is independent of the stride arithmetic.

// File: rtl/rot_fetch_agen.sv
module rot_fetch_agen #(
  parameter int AW  = 32,
  parameter int CW  = 12,
  parameter int NPL = 3,
  parameter int BW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic [1:0]        cfg_rot,
  input  logic [1:0]        cfg_planes_m1,
  input  logic [CW-1:0]     cfg_x,
  input  logic [CW-1:0]     cfg_y,
  input  logic [CW-1:0]     cfg_w,
  input  logic [CW-1:0]     cfg_h,
  input  logic [1:0]        cfg_hsub,
  input  logic [1:0]        cfg_vsub,
  input  logic [NPL*AW-1:0] cfg_pitch,
  input  logic [NPL*BW-1:0] cfg_bpp,
  input  logic [NPL*AW-1:0] cfg_base,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [AW-1:0]     out_addr,
  output logic [1:0]        out_plane,
  output logic              out_last
);

  localparam logic [CW:0] ONE   = (CW+1)'(1);
  localparam logic [1:0]  MAXPL = 2'(NPL - 1);

  typedef enum logic [1:0] {IDLE, LOAD, RUN} state_t;

  state_t              state;
  logic [AW-1:0]       ptr;
  logic [1:0]          pl, r_last_pl, r_rot, r_hs, r_vs;
  logic [CW-1:0]       r_x, r_y, r_w, r_h;
  logic [NPL*AW-1:0]   r_pitch, r_base;
  logic [NPL*BW-1:0]   r_bpp;
  logic [CW:0]         pix, line;

  function automatic logic [AW-1:0] wx(input logic [CW:0] v);
    return {{(AW-CW-1){1'b0}}, v};
  endfunction

  logic [1:0]    hs, vs;
  logic [AW-1:0] pitch, bpp, base;
  logic [CW:0]   x_lo, x_hi, y_lo, y_hi, cols_m1, rows_m1, len_m1, cnt_m1;
  logic [CW:0]   row_s, col_s;
  logic [AW-1:0] start, pstep, lstep;

  assign hs    = (pl == 2'd0) ? 2'd0 : r_hs;
  assign vs    = (pl == 2'd0) ? 2'd0 : r_vs;
  assign pitch = r_pitch[pl*AW +: AW];
  assign base  = r_base[pl*AW +: AW];
  assign bpp   = {{(AW-BW){1'b0}}, r_bpp[pl*BW +: BW]};

  assign x_lo    = {1'b0, r_x} >> hs;
  assign x_hi    = ({1'b0, r_x} + {1'b0, r_w} - ONE) >> hs;
  assign y_lo    = {1'b0, r_y} >> vs;
  assign y_hi    = ({1'b0, r_y} + {1'b0, r_h} - ONE) >> vs;
  assign cols_m1 = ({1'b0, r_w} - ONE) >> hs;
  assign rows_m1 = ({1'b0, r_h} - ONE) >> vs;
  assign len_m1  = r_rot[0] ? rows_m1 : cols_m1;
  assign cnt_m1  = r_rot[0] ? cols_m1 : rows_m1;

  assign row_s = (r_rot == 2'd0 || r_rot == 2'd1) ? y_lo : y_hi;
  assign col_s = (r_rot == 2'd0 || r_rot == 2'd3) ? x_lo : x_hi;
  assign start = base + wx(row_s) * pitch + wx(col_s) * bpp;

  always_comb begin
    case (r_rot)
      2'd0: begin
        pstep = '0;
        lstep = pitch - (wx(cols_m1) + AW'(1)) * bpp;
      end
      2'd1: begin
        pstep = pitch - bpp;
        lstep = AW'(0) - wx(rows_m1) * pitch - (bpp << 1);
      end
      2'd2: begin
        pstep = AW'(0) - (bpp << 1);
        lstep = (wx(cols_m1) - AW'(1)) * bpp - pitch;
      end
      default: begin
        pstep = AW'(0) - pitch - bpp;
        lstep = wx(rows_m1) * pitch;
      end
    endcase
  end

  logic eol, eop;
  assign eol = (pix == len_m1);
  assign eop = eol && (line == cnt_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= IDLE;
      ptr       <= '0;
      pl        <= '0;
      pix       <= '0;
      line      <= '0;
      r_last_pl <= '0;
      r_rot     <= '0;
      r_hs      <= '0;
      r_vs      <= '0;
      r_x       <= '0;
      r_y       <= '0;
      r_w       <= '0;
      r_h       <= '0;
      r_pitch   <= '0;
      r_base    <= '0;
      r_bpp     <= '0;
    end else if (sof) begin
      state     <= LOAD;
      pl        <= '0;
      r_last_pl <= (cfg_planes_m1 > MAXPL) ? MAXPL : cfg_planes_m1;
      r_rot     <= cfg_rot;
      r_hs      <= cfg_hsub;
      r_vs      <= cfg_vsub;
      r_x       <= cfg_x;
      r_y       <= cfg_y;
      r_w       <= cfg_w;
      r_h       <= cfg_h;
      r_pitch   <= cfg_pitch;
      r_base    <= cfg_base;
      r_bpp     <= cfg_bpp;
    end else begin
      case (state)
        LOAD: begin
          ptr   <= start;
          pix   <= '0;
          line  <= '0;
          state <= RUN;
        end
        RUN: if (out_ready) begin
          if (eop) begin
            if (pl == r_last_pl) state <= IDLE;
            else begin
              pl    <= pl + 2'd1;
              state <= LOAD;
            end
          end else if (eol) begin
            ptr  <= ptr + bpp + lstep;
            pix  <= '0;
            line <= line + ONE;
          end else begin
            ptr <= ptr + bpp + pstep;
            pix <= pix + ONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign out_valid = (state == RUN);
  assign out_addr  = ptr;
  assign out_plane = pl;
  assign out_last  = (state == RUN) && eop && (pl == r_last_pl);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n || sof)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_addr) && $stable(out_plane) && $stable(out_last)));

  // R10
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && !sof) |=> !out_valid);

  // R9
  plane_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !sof) |=> (!out_valid || $stable(out_plane)));

  // R2
  sof_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> !out_valid);

  // R13
  plane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_plane <= MAXPL));

endmodule

// File: tb/test_rot_fetch_agen.sv
module test_rot_fetch_agen;
  localparam int AW = 32, CW = 12, NPL = 3, BW = 3;

  logic clk = 1'b0, rst_n = 1'b0, sof = 1'b0, out_ready = 1'b0;
  logic [1:0] cfg_rot = '0, cfg_planes_m1 = '0, cfg_hsub = '0, cfg_vsub = '0;
  logic [CW-1:0] cfg_x = '0, cfg_y = '0, cfg_w = '0, cfg_h = '0;
  logic [NPL*AW-1:0] cfg_pitch = '0, cfg_base = '0;
  logic [NPL*BW-1:0] cfg_bpp = '0;
  logic out_valid, out_last;
  logic [AW-1:0] out_addr;
  logic [1:0] out_plane;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rot_fetch_agen #(.AW(AW), .CW(CW), .NPL(NPL), .BW(BW)) i_rot_fetch_agen (
    .clk(clk), .rst_n(rst_n), .sof(sof), .cfg_rot(cfg_rot),
    .cfg_planes_m1(cfg_planes_m1), .cfg_x(cfg_x), .cfg_y(cfg_y),
    .cfg_w(cfg_w), .cfg_h(cfg_h), .cfg_hsub(cfg_hsub), .cfg_vsub(cfg_vsub),
    .cfg_pitch(cfg_pitch), .cfg_bpp(cfg_bpp), .cfg_base(cfg_base),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_plane(out_plane), .out_last(out_last));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model(input int rot, input logic [31:0] base,
      input int p, input int b, input int x, input int y, input int w, input int h,
      input int s, input int t, input int l, input int k);
    int x0, x1, y0, y1, r, c;
    x0 = x >> s; x1 = (x + w - 1) >> s;
    y0 = y >> t; y1 = (y + h - 1) >> t;
    case (rot)
      0: begin r = y0 + l; c = x0 + k; end
      1: begin r = y0 + k; c = x1 - l; end
      2: begin r = y1 - l; c = x1 - k; end
      default: begin r = y1 - k; c = x0 + l; end
    endcase
    return base + 32'(r) * 32'(p) + 32'(c) * 32'(b);
  endfunction

  task automatic run_frame(input int rot, input int x, input int y, input int w,
      input int h, input int pm1, input int hsh, input int vsh, input int bpp0,
      input logic [31:0] base0, input int stall, input int max_pix, input string tagover);
    int pitches[3], bpps[3];
    logic [31:0] bases[3];
    int npl, taken;
    pitches = '{64, 24, 40};
    bpps = '{bpp0, 2, 1};
    bases = '{base0, base0 + 32'h1000, base0 + 32'h2000};
    npl = (pm1 > 2) ? 3 : pm1 + 1;
    taken = 0;
    @(negedge clk);
    out_ready = 1'b0;
    sof = 1'b1;
    cfg_rot = 2'(rot); cfg_planes_m1 = 2'(pm1);
    cfg_x = CW'(x); cfg_y = CW'(y); cfg_w = CW'(w); cfg_h = CW'(h);
    cfg_hsub = 2'(hsh); cfg_vsub = 2'(vsh);
    cfg_pitch = {32'(pitches[2]), 32'(pitches[1]), 32'(pitches[0])};
    cfg_bpp = {3'(bpps[2]), 3'(bpps[1]), 3'(bpps[0])};
    cfg_base = {bases[2], bases[1], bases[0]};
    @(negedge clk);
    sof = 1'b0;
    // R2: inputs scrambled after capture must not matter
    cfg_rot = ~cfg_rot; cfg_planes_m1 = ~cfg_planes_m1;
    cfg_x = cfg_x + 3; cfg_w = cfg_w + 5; cfg_h = cfg_h + 1;
    cfg_pitch = '1; cfg_base = '0; cfg_bpp = '1; cfg_hsub = ~cfg_hsub;
    chk("R2 bubble after sof", 32'(out_valid), 32'd0);
    @(negedge clk);
    chk("R2 first valid", 32'(out_valid), 32'd1);
    for (int p = 0; p < npl; p++) begin
      int s, t, cols, rows, len, cnt;
      string tg;
      s = (p == 0) ? 0 : hsh;
      t = (p == 0) ? 0 : vsh;
      cols = ((w - 1) >> s) + 1;
      rows = ((h - 1) >> t) + 1;
      len = (rot % 2 == 1) ? rows : cols;
      cnt = (rot % 2 == 1) ? cols : rows;
      if (tagover != "") tg = tagover;
      else if (p == 2 && pm1 == 3) tg = "R13";
      else if (p > 0) tg = "R7";
      else tg = (rot == 0) ? "R3" : (rot == 1) ? "R5" : (rot == 2) ? "R4" : "R6";
      if (p > 0) begin
        chk("R9 plane gap", 32'(out_valid), 32'd0);
        @(negedge clk);
      end
      for (int l = 0; l < cnt; l++) begin
        for (int k = 0; k < len; k++) begin
          logic [31:0] e;
          logic el;
          e = model(rot, bases[p], pitches[p], bpps[p], x, y, w, h, s, t, l, k);
          el = (p == npl - 1) && (l == cnt - 1) && (k == len - 1);
          if (max_pix >= 0 && taken == max_pix) begin
            out_ready = 1'b0;
            return;
          end
          if (stall != 0 && ((l + k) % 3 == 1)) begin
            out_ready = 1'b0;
            @(negedge clk);
            chk("R11 hold valid", 32'(out_valid), 32'd1);
            chk("R11 hold addr", out_addr, e);
          end
          out_ready = 1'b1;
          chk(tg, 32'(out_valid), 32'd1);
          chk(tg, out_addr, e);
          chk(tg, 32'(out_plane), 32'(p));
          chk("R10 last flag", 32'(out_last), 32'(el));
          taken++;
          @(negedge clk);
        end
      end
    end
    out_ready = 1'b0;
    chk("R9 idle after frame", 32'(out_valid), 32'd0);
    repeat (3) @(negedge clk);
    chk("R9 still idle", 32'(out_valid), 32'd0);
  endtask

  initial begin
    int gx[4], gy[4], gw[4], gh[4];
    gx = '{2, 0, 4, 4};
    gy = '{1, 2, 0, 2};
    gw = '{4, 6, 2, 8};
    gh = '{3, 2, 4, 2};
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 32'(out_valid), 32'd0);
    chk("R1 reset last", 32'(out_last), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle valid", 32'(out_valid), 32'd0);
    chk("R1 idle last", 32'(out_last), 32'd0);
    for (int r = 0; r < 4; r++) begin
      for (int g = 0; g < 4; g++) begin
        int hsh, vsh;
        hsh = (gx[g] % 4 == 0 && gw[g] % 4 == 0) ? 2 : 1;
        vsh = (gy[g] % 2 == 0 && gh[g] % 2 == 0) ? 1 : 0;
        run_frame(r, gx[g], gy[g], gw[g], gh[g], (r + g) % 4, hsh, vsh,
                  1 + (r + g) % 4, 32'h0001_0000, g % 2, -1, "");
      end
    end
    // R8: bases near the top of the address space wrap
    for (int r = 0; r < 4; r++)
      run_frame(r, 2, 2, 4, 2, 2, 1, 1, 3, 32'hFFFF_F000, 1, -1, "R8");
    // R12: restart mid-frame
    run_frame(0, 0, 0, 6, 4, 2, 1, 1, 2, 32'h0000_4000, 0, 5, "R12");
    run_frame(2, 2, 0, 4, 2, 1, 1, 1, 4, 32'h0008_0000, 0, -1, "R12");
    run_frame(1, 0, 0, 6, 4, 0, 0, 0, 1, 32'h0000_4000, 1, 9, "R12");
    run_frame(3, 4, 2, 2, 4, 0, 0, 0, 2, 32'h0010_0000, 0, -1, "R12");
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule